// File: doc/BRIEF.md
# ADC Conversion Queue Sequencer

This block runs analog-to-digital conversions from a 64-entry command table. Each command word selects one analog channel and a sample-time code. A pause marker in a word splits a queue into sub-queues. The table holds two queues that meet at a programmable boundary index. Queue 1 covers the entries below the boundary. Queue 2 runs from the boundary to the top of the table.

A trigger pulse starts an idle queue at its first entry, or resumes a paused queue at the entry after the pause. The sequencer handles one conversion at a time. It raises a one-cycle start strobe together with the channel and sample code, then waits for the converter's end-of-conversion pulse. At that pulse it stores the converter's result in a 64-entry result table, at the index of the command word just converted.

Queue 1 has priority. When queue 1 is triggered while queue 2 is converting, the running conversion finishes, queue 1 runs, and queue 2 then continues from where it stopped. Each queue has three sticky status flags: paused, finished and trigger overrun. A single clear input resets all six.

Top module: `adcq_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no trigger, `conv_start` is 0 and all six status flags are 0.
- R2: A command word is 10 bits. Bit 9 is the pause marker, bits 8:7 are the sample-time code and bits 6:0 are the channel. A trigger on an idle queue issues its entries in ascending index order, starting at index 0 for queue 1 and at `q2_base` for queue 2. Each start presents the word's channel on `conv_chan` and its sample code on `conv_stime`.
- R3: On each `conv_eoc`, `conv_result` is written to the result table at the index of the command word being converted, and can be read combinationally through `res_raddr`/`res_rdata`.
- R4: Queue 1 ends after index `q2_base`-1 and queue 2 ends after index 63. On reaching its end, a queue goes idle and sets its finished flag, and no start is issued in that cycle.
- R5: A command word whose channel field is 7'h7F ends its queue. No conversion is made for it, and the finished flag is set.
- R6: When the converted word has its pause marker set, the queue stops after that word's `conv_eoc` and sets its paused flag. The next trigger continues at the following index.
- R7: A trigger arriving while its queue is running (including a cycle in which the queue is converting its last entry) sets that queue's overrun flag and has no other effect.
- R8: If queue 1 is triggered while queue 2 is converting, that conversion completes, queue 1's entries are issued next, and queue 2 then continues at its next index.
- R9: `flag_clr` clears all six flags at the next edge. A flag set in the same cycle stays set.
- R10: `conv_start` is a single-cycle pulse, and no new start is issued until the previous conversion has delivered `conv_eoc`.
- R11: After a queue has finished, a new trigger restarts it at its first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command table write enable |
| cmd_waddr | input | 6 | Command table write index |
| cmd_wdata | input | 10 | Command word: {pause, sample code[1:0], channel[6:0]} |
| q2_base | input | 7 | First table index of queue 2 (0..64) |
| trig1 | input | 1 | Queue 1 trigger pulse |
| trig2 | input | 1 | Queue 2 trigger pulse |
| flag_clr | input | 1 | Clears all status flags |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 7 | Channel for the conversion being started |
| conv_stime | output | 2 | Sample-time code for the conversion being started |
| conv_eoc | input | 1 | End-of-conversion pulse from the converter |
| conv_result | input | 10 | Converter result, valid with `conv_eoc` |
| res_raddr | input | 6 | Result table read index |
| res_rdata | output | 10 | Result table read data |
| q1_pause | output | 1 | Queue 1 stopped at a pause marker |
| q1_done | output | 1 | Queue 1 finished |
| q1_ovr | output | 1 | Queue 1 triggered while running |
| q2_pause | output | 1 | Queue 2 stopped at a pause marker |
| q2_done | output | 1 | Queue 2 finished |
| q2_ovr | output | 1 | Queue 2 triggered while running |

## Verification
The sequencer is run on several table layouts. A plain eight-entry queue 1 checks ordering and index-matched storage. A pause marker in the middle checks that the resume index is exact. An end-of-queue code inside queue 2 separates a code-based stop from the range-based stop, and a boundary at 60 checks that queue 2 stops at the top of the table. Triggering queue 1 during a queue 2 conversion reveals whether the arbitration drops, repeats or reorders entries. Retriggers while running, including one in the same cycle as `flag_clr`, check the overrun flag and that a set wins over a clear. Converter latency changes from one conversion to the next, so a sequencer that issues a start before `conv_eoc` cannot match the reference.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  typedef enum logic [1:0] {
    Q_IDLE = 2'd0,
    Q_WAIT = 2'd1,
    Q_RUN  = 2'd2
  } qstate_e;

  typedef enum logic {
    E_IDLE = 1'b0,
    E_CONV = 1'b1
  } estate_e;
endpackage

// File: rtl/adcq_table.sv
module adcq_table #(
  parameter int W     = 10,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/adcq_queue_ctl.sv
module adcq_queue_ctl
  import adcq_pkg::*;
#(
  parameter int AW  = 6,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          flag_clr,
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] limit,
  input  logic          issue,
  input  logic          finish,
  input  logic          pause_hit,
  output logic          running,
  output logic [AW-1:0] ptr,
  output logic          at_end,
  output logic          pause_flag,
  output logic          done_flag,
  output logic          ovr_flag
);
  qstate_e       state_q, state_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          pf_q, pf_d, df_q, df_d, of_q, of_d;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    pf_d    = flag_clr ? 1'b0 : pf_q;
    df_d    = flag_clr ? 1'b0 : df_q;
    of_d    = flag_clr ? 1'b0 : of_q;
    if (issue) begin
      ptr_d = ptr_q + 1'b1;
    end
    if (finish) begin
      state_d = Q_IDLE;
      df_d    = 1'b1;
    end
    if (pause_hit) begin
      state_d = Q_WAIT;
      pf_d    = 1'b1;
    end
    if (trig) begin
      unique case (state_q)
        Q_RUN:   of_d = 1'b1;
        Q_IDLE: begin
          state_d = Q_RUN;
          ptr_d   = base;
        end
        Q_WAIT:  state_d = Q_RUN;
        default: state_d = Q_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= Q_IDLE;
      ptr_q   <= '0;
      pf_q    <= 1'b0;
      df_q    <= 1'b0;
      of_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      pf_q    <= pf_d;
      df_q    <= df_d;
      of_q    <= of_d;
    end
  end

  assign running    = (state_q == Q_RUN);
  assign ptr        = ptr_q[AW-1:0];
  assign at_end     = (ptr_q >= limit);
  assign pause_flag = pf_q;
  assign done_flag  = df_q;
  assign ovr_flag   = of_q;
endmodule

// File: rtl/adcq_engine.sv
module adcq_engine
  import adcq_pkg::*;
#(
  parameter int AW  = 6,
  parameter int CHW = 7,
  parameter int STW = 2,
  parameter int RW  = 10,
  localparam int CW = 1 + STW + CHW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     run_v,
  input  logic [1:0]     end_v,
  input  logic [AW-1:0]  ptr0,
  input  logic [AW-1:0]  ptr1,
  output logic [AW-1:0]  cmd_addr,
  input  logic [CW-1:0]  cmd_word,
  output logic [1:0]     issue_v,
  output logic [1:0]     finish_v,
  output logic [1:0]     pause_v,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  output logic [STW-1:0] conv_stime,
  input  logic           conv_eoc,
  input  logic [RW-1:0]  conv_result,
  output logic           res_we,
  output logic [AW-1:0]  res_addr,
  output logic [RW-1:0]  res_data
);
  estate_e        est_q, est_d;
  logic           start_q;
  logic           q2_q;
  logic [AW-1:0]  idx_q;
  logic           pause_q;
  logic [CHW-1:0] chan_q;
  logic [STW-1:0] st_q;
  logic           pick2, any_run, sel_end, eoq, launch, stop, land;

  always_comb begin
    pick2    = !run_v[0];
    any_run  = |run_v;
    cmd_addr = pick2 ? ptr1 : ptr0;
    sel_end  = pick2 ? end_v[1] : end_v[0];
    eoq      = (cmd_word[CHW-1:0] == {CHW{1'b1}});
    launch   = (est_q == E_IDLE) && any_run && !(sel_end || eoq);
    stop     = (est_q == E_IDLE) && any_run && (sel_end || eoq);
    land     = (est_q == E_CONV) && conv_eoc;
    issue_v  = {launch && pick2, launch && !pick2};
    finish_v = {stop && pick2, stop && !pick2};
    pause_v  = {land && pause_q && q2_q, land && pause_q && !q2_q};
    est_d    = est_q;
    if (launch) begin
      est_d = E_CONV;
    end else if (land) begin
      est_d = E_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q   <= E_IDLE;
      start_q <= 1'b0;
    end else begin
      est_q   <= est_d;
      start_q <= launch;
    end
  end

  always_ff @(posedge clk) begin
    if (launch) begin
      q2_q    <= pick2;
      idx_q   <= cmd_addr;
      pause_q <= cmd_word[CW-1];
      chan_q  <= cmd_word[CHW-1:0];
      st_q    <= cmd_word[CHW +: STW];
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign conv_stime = st_q;
  assign res_we     = land;
  assign res_addr   = idx_q;
  assign res_data   = conv_result;
endmodule

// File: rtl/adcq_seq.sv
module adcq_seq #(
  parameter int DEPTH = 64,
  parameter int CHW   = 7,
  parameter int STW   = 2,
  parameter int RW    = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int CW   = 1 + STW + CHW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_we,
  input  logic [AW-1:0]  cmd_waddr,
  input  logic [CW-1:0]  cmd_wdata,
  input  logic [PW-1:0]  q2_base,
  input  logic           trig1,
  input  logic           trig2,
  input  logic           flag_clr,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  output logic [STW-1:0] conv_stime,
  input  logic           conv_eoc,
  input  logic [RW-1:0]  conv_result,
  input  logic [AW-1:0]  res_raddr,
  output logic [RW-1:0]  res_rdata,
  output logic           q1_pause,
  output logic           q1_done,
  output logic           q1_ovr,
  output logic           q2_pause,
  output logic           q2_done,
  output logic           q2_ovr
);
  logic [1:0]    trig_v, run_v, end_v, issue_v, finish_v, pause_v;
  logic [1:0]    pf_v, df_v, of_v;
  logic [AW-1:0] ptr_v [2];
  logic [AW-1:0] cmd_raddr;
  logic [CW-1:0] cmd_rdata;
  logic          res_we;
  logic [AW-1:0] res_waddr;
  logic [RW-1:0] res_wdata;

  assign trig_v = {trig2, trig1};

  adcq_table #(.W(CW), .DEPTH(DEPTH)) u_cmd_tbl (
    .clk   (clk),
    .we    (cmd_we),
    .waddr (cmd_waddr),
    .wdata (cmd_wdata),
    .raddr (cmd_raddr),
    .rdata (cmd_rdata)
  );

  adcq_table #(.W(RW), .DEPTH(DEPTH)) u_res_tbl (
    .clk   (clk),
    .we    (res_we),
    .waddr (res_waddr),
    .wdata (res_wdata),
    .raddr (res_raddr),
    .rdata (res_rdata)
  );

  for (genvar g = 0; g < 2; g++) begin : g_queue
    logic [PW-1:0] base_g, limit_g;
    if (g == 0) begin : g_lower
      assign base_g  = '0;
      assign limit_g = q2_base;
    end else begin : g_upper
      assign base_g  = q2_base;
      assign limit_g = PW'(DEPTH);
    end
    adcq_queue_ctl #(.AW(AW)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig_v[g]),
      .flag_clr   (flag_clr),
      .base       (base_g),
      .limit      (limit_g),
      .issue      (issue_v[g]),
      .finish     (finish_v[g]),
      .pause_hit  (pause_v[g]),
      .running    (run_v[g]),
      .ptr        (ptr_v[g]),
      .at_end     (end_v[g]),
      .pause_flag (pf_v[g]),
      .done_flag  (df_v[g]),
      .ovr_flag   (of_v[g])
    );
  end

  adcq_engine #(.AW(AW), .CHW(CHW), .STW(STW), .RW(RW)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_v       (run_v),
    .end_v       (end_v),
    .ptr0        (ptr_v[0]),
    .ptr1        (ptr_v[1]),
    .cmd_addr    (cmd_raddr),
    .cmd_word    (cmd_rdata),
    .issue_v     (issue_v),
    .finish_v    (finish_v),
    .pause_v     (pause_v),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .conv_stime  (conv_stime),
    .conv_eoc    (conv_eoc),
    .conv_result (conv_result),
    .res_we      (res_we),
    .res_addr    (res_waddr),
    .res_data    (res_wdata)
  );

  assign q1_pause = pf_v[0];
  assign q1_done  = df_v[0];
  assign q1_ovr   = of_v[0];
  assign q2_pause = pf_v[1];
  assign q2_done  = df_v[1];
  assign q2_ovr   = of_v[1];
endmodule

// File: rtl/adcq_seq_chk.sv
module adcq_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic conv_eoc,
  input logic trig1,
  input logic trig2,
  input logic flag_clr,
  input logic q1_pause,
  input logic q1_done,
  input logic q1_ovr,
  input logic q2_ovr
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (conv_start) begin
      pending_q <= 1'b1;
    end else if (conv_eoc) begin
      pending_q <= 1'b0;
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !pending_q);

  a_r7_ovr_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q1_ovr) |-> $past(trig1));

  a_r6_pause_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q1_pause) |-> $past(conv_eoc));

  a_r9_clear_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !trig1 && !trig2) |=> (!q1_ovr && !q2_ovr));

  a_r4_done_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q1_done) |-> !conv_start);
endmodule

bind adcq_seq adcq_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_eoc   (conv_eoc),
  .trig1      (trig1),
  .trig2      (trig2),
  .flag_clr   (flag_clr),
  .q1_pause   (q1_pause),
  .q1_done    (q1_done),
  .q1_ovr     (q1_ovr),
  .q2_ovr     (q2_ovr)
);

// File: tb/adcq_seq_bench.sv
module adcq_seq_bench;
  logic       clk;
  logic       rst_n;
  logic       cmd_we;
  logic [5:0] cmd_waddr;
  logic [9:0] cmd_wdata;
  logic [6:0] q2_base;
  logic       trig1, trig2, flag_clr;
  logic       conv_start;
  logic [6:0] conv_chan;
  logic [1:0] conv_stime;
  logic       conv_eoc;
  logic [9:0] conv_result;
  logic [5:0] res_raddr;
  logic [9:0] res_rdata;
  logic       q1_pause, q1_done, q1_ovr, q2_pause, q2_done, q2_ovr;

  int checks;
  int fails;

  adcq_seq u_adcq_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_waddr(cmd_waddr),
    .cmd_wdata(cmd_wdata), .q2_base(q2_base), .trig1(trig1), .trig2(trig2),
    .flag_clr(flag_clr), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_stime(conv_stime), .conv_eoc(conv_eoc), .conv_result(conv_result),
    .res_raddr(res_raddr), .res_rdata(res_rdata), .q1_pause(q1_pause),
    .q1_done(q1_done), .q1_ovr(q1_ovr), .q2_pause(q2_pause),
    .q2_done(q2_done), .q2_ovr(q2_ovr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 paused, 2 running
  int         mqs [2];
  int         mqp [2];
  bit         mpf [2];
  bit         mdf [2];
  bit         mof [2];
  bit         mbusy;
  int         mcq, midx;
  bit         mcp;
  bit         m_start;
  int         m_chan, m_st;
  logic [9:0] m_cmd [64];
  logic [9:0] m_res [64];

  always @(posedge clk or negedge rst_n) begin
    int  oqs [2];
    bit  npf [2];
    bit  ndf [2];
    bit  nof [2];
    int  s, lim, p;
    bit  trg;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        mqs[k] = 0; mqp[k] = 0; mpf[k] = 0; mdf[k] = 0; mof[k] = 0;
      end
      mbusy = 0;
      m_start = 0;
    end else begin
      oqs = mqs;
      for (int k = 0; k < 2; k++) begin
        npf[k] = flag_clr ? 1'b0 : mpf[k];
        ndf[k] = flag_clr ? 1'b0 : mdf[k];
        nof[k] = flag_clr ? 1'b0 : mof[k];
      end
      m_start = 0;
      if (!mbusy && (oqs[0] == 2 || oqs[1] == 2)) begin
        s   = (oqs[0] == 2) ? 0 : 1;
        lim = (s == 0) ? int'(q2_base) : 64;
        p   = mqp[s];
        if (p >= lim || m_cmd[p][6:0] == 7'h7F) begin
          mqs[s] = 0;
          ndf[s] = 1;
        end else begin
          mbusy = 1; mcq = s; midx = p; mcp = m_cmd[p][9];
          m_start = 1; m_chan = int'(m_cmd[p][6:0]); m_st = int'(m_cmd[p][8:7]);
          mqp[s] = p + 1;
        end
      end else if (mbusy && conv_eoc) begin
        m_res[midx] = conv_result;
        if (mcp) begin
          mqs[mcq] = 1;
          npf[mcq] = 1;
        end
        mbusy = 0;
      end
      for (int k = 0; k < 2; k++) begin
        trg = (k == 0) ? trig1 : trig2;
        if (trg) begin
          if (oqs[k] == 2) nof[k] = 1;
          else if (oqs[k] == 0) begin
            mqs[k] = 2;
            mqp[k] = (k == 0) ? 0 : int'(q2_base);
          end else mqs[k] = 2;
        end
      end
      mpf = npf; mdf = ndf; mof = nof;
      if (cmd_we) m_cmd[cmd_waddr] = cmd_wdata;
    end
  end

  // Converter model with varying latency
  int         cnv_cnt;
  int         cnv_seq;
  logic [6:0] cnv_chan;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_eoc = 1'b0; conv_result = '0; cnv_cnt = 0; cnv_seq = 0; cnv_chan = '0;
    end else begin
      conv_eoc = 1'b0;
      if (conv_start) begin
        cnv_cnt  = 1 + (cnv_seq % 3);
        cnv_chan = conv_chan;
      end else if (cnv_cnt > 0) begin
        cnv_cnt--;
        if (cnv_cnt == 0) begin
          conv_eoc    = 1'b1;
          conv_result = {cnv_seq[2:0], cnv_chan};
          cnv_seq++;
        end
      end
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 conv_start", 32'(conv_start), 32'(m_start));
      if (m_start) begin
        chk("R2 conv_chan", 32'(conv_chan), 32'(m_chan));
        chk("R2 conv_stime", 32'(conv_stime), 32'(m_st));
      end
      chk("R6 q1_pause", 32'(q1_pause), 32'(mpf[0]));
      chk("R6 q2_pause", 32'(q2_pause), 32'(mpf[1]));
      chk("R4 q1_done", 32'(q1_done), 32'(mdf[0]));
      chk("R4 q2_done", 32'(q2_done), 32'(mdf[1]));
      chk("R7 q1_ovr", 32'(q1_ovr), 32'(mof[0]));
      chk("R7 q2_ovr", 32'(q2_ovr), 32'(mof[1]));
    end
  end

  task automatic wr(input int a, input logic [9:0] d);
    @(negedge clk);
    cmd_we = 1'b1; cmd_waddr = 6'(a); cmd_wdata = d;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 1) trig1 = 1'b1;
    else if (which == 2) trig2 = 1'b1;
    else flag_clr = 1'b1;
    @(negedge clk);
    trig1 = 1'b0; trig2 = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mbusy || mqs[0] == 2 || mqs[1] == 2) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_res(input string tag, input int a);
    @(negedge clk);
    res_raddr = 6'(a);
    #1;
    chk(tag, 32'(res_rdata), 32'(m_res[a]));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; cmd_we = 1'b0; cmd_waddr = '0; cmd_wdata = '0;
    q2_base = 7'd8; trig1 = 1'b0; trig2 = 1'b0; flag_clr = 1'b0; res_raddr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 conv_start", 32'(conv_start), 0);
    chk("R1 flags", 32'({q1_pause, q1_done, q1_ovr, q2_pause, q2_done, q2_ovr}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) wr(i, {1'b0, 2'(i % 4), 7'(i)});
    chk("R1 flags idle", 32'({q1_pause, q1_done, q1_ovr, q2_pause, q2_done, q2_ovr}), 0);

    // Plain queue 1 run over entries 0..7
    pulse(1);
    wait_idle();
    chk("R4 q1 finished at boundary", 32'(q1_done), 1);
    for (int i = 0; i < 8; i++) read_res("R3 result index", i);

    // Pause in the middle, then resume
    pulse(3);
    chk("R9 flags cleared", 32'({q1_done, q1_ovr}), 0);
    wr(3, {1'b1, 2'd3, 7'd3});
    pulse(1);
    wait_idle();
    chk("R6 q1 paused", 32'(q1_pause), 1);
    chk("R6 q1 not done", 32'(q1_done), 0);
    read_res("R11 restart rewrote index 0", 0);
    pulse(1);
    wait_idle();
    chk("R6 resume reached end", 32'(q1_done), 1);
    read_res("R6 resumed entry 4", 4);

    // End-of-queue code inside queue 2
    pulse(3);
    wr(12, 10'h07F);
    pulse(2);
    wait_idle();
    chk("R5 q2 done at end code", 32'(q2_done), 1);
    for (int i = 8; i < 12; i++) read_res("R3 q2 result", i);

    // Queue 1 preempts queue 2 between conversions
    pulse(3);
    wr(3, {1'b0, 2'd3, 7'd3});
    pulse(2);
    while (!conv_start) @(negedge clk);
    pulse(1);
    wait_idle();
    chk("R8 both queues done", 32'({q1_done, q2_done}), 32'h3);
    read_res("R8 q2 entry after resume", 11);

    // Retrigger while running
    pulse(3);
    pulse(1);
    repeat (3) @(negedge clk);
    pulse(1);
    wait_idle();
    chk("R7 q1 overrun", 32'(q1_ovr), 1);
    chk("R7 q2 untouched", 32'(q2_ovr), 0);

    // Clear and set in the same cycle: set wins
    pulse(3);
    pulse(1);
    repeat (2) @(negedge clk);
    @(negedge clk);
    flag_clr = 1'b1; trig1 = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0; trig1 = 1'b0;
    chk("R9 set beats clear", 32'(q1_ovr), 1);
    wait_idle();

    // Queue 2 runs to the top of the table
    q2_base = 7'd60;
    wr(12, {1'b0, 2'd0, 7'd12});
    pulse(3);
    pulse(2);
    wait_idle();
    chk("R4 q2 done at table top", 32'(q2_done), 1);
    for (int i = 60; i < 64; i++) read_res("R3 top results", i);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule